// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescaler

This block supervises software by counting time and raising a one-cycle reset request when software has not cleared the count in time. It counts either CPU-clock enable ticks or ticks from a low-speed RC oscillator. Those ticks feed a prescaler whose length is chosen by software. The prescaler drives a divide-by-16 stage, and the reset request is raised when that stage wraps.

An 8-bit control register holds the watchdog fields and a few clock-control fields that are kept for the surrounding logic. These fields are a source select, a clear strobe, a rate select, a two-bit CPU mode, a slow-mode flag and an oscillator-stop flag. The watchdog reads the CPU mode field and stops counting while the CPU is in sleep or green mode. The count holds its value during that time and counting carries on once the CPU mode returns to normal.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the register reads 0x00 and the reset request is low.
- R2: A register write stores bit 7 as the source select, bit 5 as the rate, bits 4:3 as the CPU mode, bit 2 as slow mode and bit 1 as oscillator stop. Bit 6 (clear) and bit 0 always read as 0.
- R3: With source 0 and rate 0, the reset request rises in the cycle after the tick that completes 16·2^SLOW_LOG2 counted CPU ticks from zero.
- R4: With source 0 and rate 1, the same happens after 16·2^FAST_LOG2 counted CPU ticks.
- R5: With source 1, only RC ticks count, the period is 16·2^RC_LOG2 ticks, and the rate bit and the CPU ticks are ignored.
- R6: With source 0, RC ticks are ignored.
- R7: The reset request is high for exactly one cycle. The count then restarts from zero, so the next request needs a further full period.
- R8: A write with bit 6 set zeroes both the prescaler and the divide-by-16 stage. A write with bit 6 clear leaves the count untouched.
- R9: In mode 01 (sleep) or mode 10 (green), ticks are not counted and the count holds its value. Counting resumes from the held value when the mode returns to 00.
- R10: Mode 11 counts exactly like mode 00.
- R11: A clear written in the cycle where the count would overflow wins, and no reset request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_tick | input | 1 | One-cycle enable per CPU clock period |
| rc_tick | input | 1 | One-cycle enable per RC oscillator period, already synchronized |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| wdt_rst | output | 1 | One-cycle reset request |

## Verification
The assertions rely on two assumptions. The tick inputs are treated as plain enables that are synchronous to clk. A write is assumed to change the mode and source fields only at the clock edge, so the fields that govern counting in a cycle are the ones already held in the register. The stimulus drives every input shortly after a rising edge and holds it for a whole cycle. It never pulses a tick for less than a cycle. It builds each scenario from that discipline: mixed tick sources, writes that fall between ticks, a clear that lands exactly on the overflow tick, and stretches in each low-power mode.

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int FAST_LOG2 = 8,
  parameter int SLOW_LOG2 = 14,
  parameter int RC_LOG2   = 9,
  parameter int OVF_LOG2  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_tick,
  input  logic       rc_tick,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       wdt_rst
);
  localparam int PRE_W = (SLOW_LOG2 > FAST_LOG2) ?
                         ((SLOW_LOG2 > RC_LOG2) ? SLOW_LOG2 : RC_LOG2) :
                         ((FAST_LOG2 > RC_LOG2) ? FAST_LOG2 : RC_LOG2);
  localparam logic [PRE_W-1:0] FAST_MASK = {PRE_W{1'b1}} >> (PRE_W - FAST_LOG2);
  localparam logic [PRE_W-1:0] SLOW_MASK = {PRE_W{1'b1}} >> (PRE_W - SLOW_LOG2);
  localparam logic [PRE_W-1:0] RC_MASK   = {PRE_W{1'b1}} >> (PRE_W - RC_LOG2);

  logic             src_rc_q, rate_q, slow_q, ostop_q;
  logic [1:0]       mode_q;
  logic [PRE_W-1:0] pre_q;
  logic [OVF_LOG2-1:0] ovf_q;

  wire clr      = reg_wr & reg_wdata[6];
  wire susp     = (mode_q == 2'b01) || (mode_q == 2'b10);
  wire tick     = (src_rc_q ? rc_tick : cpu_tick) & ~susp;
  wire [PRE_W-1:0] mask = src_rc_q ? RC_MASK : (rate_q ? FAST_MASK : SLOW_MASK);
  wire pre_wrap = tick && ((pre_q & mask) == mask);
  wire ovf      = pre_wrap && (ovf_q == {OVF_LOG2{1'b1}});

  assign reg_rdata = {src_rc_q, 1'b0, rate_q, mode_q, slow_q, ostop_q, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_rc_q <= 1'b0;
      rate_q   <= 1'b0;
      mode_q   <= 2'b00;
      slow_q   <= 1'b0;
      ostop_q  <= 1'b0;
    end else if (reg_wr) begin
      src_rc_q <= reg_wdata[7];
      rate_q   <= reg_wdata[5];
      mode_q   <= reg_wdata[4:3];
      slow_q   <= reg_wdata[2];
      ostop_q  <= reg_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      ovf_q   <= '0;
      wdt_rst <= 1'b0;
    end else begin
      wdt_rst <= ovf & ~clr;
      if (clr) begin
        pre_q <= '0;
        ovf_q <= '0;
      end else if (pre_wrap) begin
        pre_q <= '0;
        ovf_q <= ovf_q + 1'b1;
      end else if (tick) begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  p_reg_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_rdata[7] == $past(reg_wdata[7])) && (reg_rdata[5:1] == $past(reg_wdata[5:1])));

  p_quiet_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_rc_q && !rc_tick) || (!src_rc_q && !cpu_tick)) |=> !wdt_rst);

  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> (pre_q == '0) && (ovf_q == '0));

  p_hold_when_suspended_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == 2'b01 || mode_q == 2'b10) && !(reg_wr && reg_wdata[6]))
      |=> $stable(pre_q) && $stable(ovf_q) && !wdt_rst);

  p_clear_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[6]) |=> !wdt_rst && (pre_q == '0) && (ovf_q == '0));
endmodule

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
  localparam int FL = 2, SL = 4, RL = 3;
  localparam int P_FAST = 16 << FL, P_SLOW = 16 << SL, P_RC = 16 << RL;

  logic clk = 0, rst_n = 0, cpu_tick = 0, rc_tick = 0, reg_wr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic wdt_rst;

  wdog_timer #(.FAST_LOG2(FL), .SLOW_LOG2(SL), .RC_LOG2(RL), .OVF_LOG2(4)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .rc_tick(rc_tick),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wdt_rst(wdt_rst));

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit q_rst[$];
  logic [8:0] q_rd[$];
  string q_tag[$];

  bit m_src = 0, m_rate = 0;
  logic [1:0] m_mode = 0;
  int m_cnt = 0;

  function automatic int period();
    return m_src ? P_RC : (m_rate ? P_FAST : P_SLOW);
  endfunction

  task automatic step(input bit cpu, input bit rc, input bit wr, input logic [7:0] wd,
                      input string tag);
    bit e = 0;
    bit tk;
    @(posedge clk); #2;
    cpu_tick = cpu; rc_tick = rc; reg_wr = wr; reg_wdata = wd;
    tk = (m_src ? rc : cpu) && !(m_mode == 2'b01 || m_mode == 2'b10);
    if (wr && wd[6]) m_cnt = 0;
    else if (tk) begin
      m_cnt++;
      if (m_cnt == period()) begin e = 1; m_cnt = 0; end
    end
    if (wr) begin m_src = wd[7]; m_rate = wd[5]; m_mode = wd[4:3]; end
    q_rst.push_back(e);
    q_rd.push_back(wr ? {1'b1, wd[7], 1'b0, wd[5:1], 1'b0} : 9'h0);
    q_tag.push_back(tag);
  endtask

  task automatic ticks(input int n, input bit use_rc, input string tag);
    for (int i = 0; i < n; i++) step(!use_rc, use_rc, 0, 8'h00, tag);
  endtask

  task automatic wr(input logic [7:0] v, input string tag);
    step(0, 0, 1, v, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      if (q_rst.size() > 0) begin
        bit e;
        logic [8:0] r;
        string t;
        e = q_rst.pop_front(); r = q_rd.pop_front(); t = q_tag.pop_front();
        n_cmp++;
        if (wdt_rst !== e) begin
          n_bad++;
          $display("FAIL %s: wdt_rst=%0b expected %0b at %0t", t, wdt_rst, e, $time);
        end
        if (r[8]) begin
          n_cmp++;
          if (reg_rdata !== r[7:0]) begin
            n_bad++;
            $display("FAIL %s: reg_rdata=%02h expected %02h", t, reg_rdata, r[7:0]);
          end
        end
      end
    end
  end

  initial begin
    #100000000;
    n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    n_cmp += 2;
    if (reg_rdata !== 8'h00 || wdt_rst !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: rdata=%02h rst=%0b expected 00 0", reg_rdata, wdt_rst);
    end
    rst_n = 1;
    ticks(3, 0, "R1 idle after reset");
    // R2: every field written, clear and bit 0 read back as 0
    wr(8'hFF, "R2");
    wr(8'h96, "R2");
    wr(8'h00, "R2");
    // R4 fast rate, then R7 restart for a second period
    wr(8'h60, "R4");
    ticks(P_FAST, 0, "R4");
    ticks(P_FAST, 0, "R7");
    for (int i = 0; i < 20; i++) begin
      step(1, 0, 0, 8'h00, "R7 gapped");
      step(0, 0, 0, 8'h00, "R7 gapped");
    end
    // R3 slow rate
    wr(8'h40, "R3");
    ticks(P_SLOW, 0, "R3");
    // R5 RC source, rate ignored, CPU ticks ignored
    wr(8'hE0, "R5");
    for (int i = 0; i < P_RC; i++) begin
      step(1, 0, 0, 8'h00, "R5 cpu ignored");
      step(1, 1, 0, 8'h00, "R5");
    end
    wr(8'hC0, "R5 rate0");
    ticks(P_RC, 1, "R5 rate0");
    // R6 RC ignored with CPU source
    wr(8'h60, "R6");
    ticks(100, 1, "R6");
    ticks(P_FAST, 0, "R6");
    // R8 clear bit 0 has no effect; clear bit 1 zeroes
    ticks(40, 0, "R8");
    wr(8'h20, "R8 no clear");
    ticks(P_FAST - 40, 0, "R8");
    ticks(40, 0, "R8");
    wr(8'h60, "R8 clear");
    ticks(P_FAST, 0, "R8");
    // R9 sleep and green hold, resume
    ticks(30, 0, "R9");
    wr(8'h28, "R9 sleep");
    ticks(50, 0, "R9 sleep");
    wr(8'h30, "R9 green");
    ticks(50, 0, "R9 green");
    wr(8'h20, "R9 normal");
    ticks(P_FAST - 30, 0, "R9 resume");
    // R10 reserved mode counts
    wr(8'h78, "R10");
    ticks(P_FAST, 0, "R10");
    ticks(P_FAST, 0, "R10");
    // R11 clear on overflow cycle
    wr(8'h60, "R11");
    ticks(P_FAST - 1, 0, "R11");
    step(1, 0, 1, 8'h60, "R11 clear wins");
    ticks(P_FAST, 0, "R11");
    step(0, 0, 0, 8'h00, "R11 tail");
    repeat (3) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule